// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when a memory controller must send AUTO REFRESH commands. The memory must receive a fixed number of refreshes (4096 by default) in every refresh period. The block counts that period and raises a refresh request toward the command arbiter. The arbiter grants a request by asserting an acknowledge in a cycle where the request is high. The request carries no address, because the memory supplies the row to refresh itself.

Two policies are available, and a single mode input selects between them. In spread mode, one refresh falls due every `REF_PERIOD / REF_QUOTA` cycles, rounded down, so the quota is spread evenly across the period. In burst mode, the whole quota falls due back to back at the start of each period, one every `RC_CYCLES` cycles. In both modes, any two granted refreshes are at least `RC_CYCLES` cycles apart.

Refreshes that fall due but have not been granted accumulate in an owed counter. That counter is visible at the ports and saturates at `OWED_MAX`, which is 8 by default. A full flag reports saturation. Any refresh that falls due while the counter is full is lost.

Top module: `refresh_sched`

## Requirements
- R1: While reset is active and in the first cycle after it, `refReq` is 0, `owedCount` is 0 and `owedFull` is 0.
- R2: Spread mode (`modeBurst`=0). With I = floor(REF_PERIOD/REF_QUOTA) and cycle 0 being the first cycle of a period, refresh k (k = 1..REF_QUOTA) is owed from cycle k*I onward. With an acknowledge held high, it is granted in exactly that cycle.
- R3: Burst mode (`modeBurst`=1). Refresh k of a period is owed from cycle k*RC_CYCLES onward. With an acknowledge held high, grants occur at cycles RC_CYCLES, 2*RC_CYCLES, ... REF_QUOTA*RC_CYCLES of the period.
- R4: Exactly REF_QUOTA refreshes fall due in each period. The first period begins in the first cycle after reset is released, and a new period begins every REF_PERIOD cycles after that.
- R5: `modeBurst` is sampled only in cycle 0 of each period. A change made in the middle of a period takes effect at the next period.
- R6: A grant happens at a rising clock edge where both `refReq` and `refAck` are 1, and each grant retires one owed refresh. `refReq` stays high until it is granted. An acknowledge while `refReq` is 0 has no effect.
- R7: Two grants are never closer together than RC_CYCLES clock cycles.
- R8: The owed count never exceeds OWED_MAX. A refresh that falls due at OWED_MAX is lost. `owedFull` is 1 exactly when the owed count equals OWED_MAX.
- R9: `owedCount` shows the number of refreshes that are owed and not yet granted. It rises by 1 in the cycle after each one falls due, unless that refresh is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeBurst | input | 1 | 1 selects burst policy, 0 selects spread policy |
| refAck | input | 1 | Arbiter grant of the pending refresh |
| refReq | output | 1 | A refresh is owed and may be issued now |
| owedCount | output | $clog2(OWED_MAX+1) | Refreshes owed and not yet granted |
| owedFull | output | 1 | Owed counter is saturated |

## Verification
The assertions assume three things about the parameters. First, REF_QUOTA*RC_CYCLES fits within REF_PERIOD. Second, the spread interval is at least one cycle. Third, `refAck` may be high at any time, including while no request is pending. The stimulus uses a short period with a small quota that meets these limits. It keeps the acknowledge high for long stretches, so that the acknowledges arriving with no request are exercised. It also withholds the acknowledge across a full period to force saturation and a lost period. The mode input changes only in mid-period, so each change is seen to wait for the next period boundary.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;            // one refresh falls due this cycle
    logic spacingRestart;  // restart the spacing counter
    logic accept;          // request granted at this edge
  } ctrlStrobes_t;

  // status from datapath to control (all derived from registers)
  typedef struct packed {
    logic periodStart;
    logic periodEnd;
    logic hitSpread;
    logic hitBurst;
    logic quotaDone;
    logic reqLive;
    logic owedAtMax;
  } dpFlags_t;

endpackage

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int REF_PERIOD = 6400000,
  parameter int REF_QUOTA  = 4096,
  parameter int RC_CYCLES  = 7,
  parameter int OWED_MAX   = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobes_t                      strobes,
  output dpFlags_t                          flags,
  output logic [$clog2(OWED_MAX+1)-1:0]     owedCount
);

  localparam int INTERVAL = REF_PERIOD / REF_QUOTA;
  localparam int SPC_MAX  = (INTERVAL > RC_CYCLES) ? INTERVAL : RC_CYCLES;
  localparam int PER_W    = $clog2(REF_PERIOD);
  localparam int SPC_W    = $clog2(SPC_MAX + 1);
  localparam int GEN_W    = $clog2(REF_QUOTA + 1);
  localparam int GAP_W    = $clog2(RC_CYCLES + 1);
  localparam int OWED_W   = $clog2(OWED_MAX + 1);

  localparam logic [PER_W-1:0]  PER_LAST   = PER_W'(REF_PERIOD - 1);
  localparam logic [SPC_W-1:0]  SPR_LAST   = SPC_W'(INTERVAL - 1);
  localparam logic [SPC_W-1:0]  BRS_LAST   = SPC_W'(RC_CYCLES - 1);
  localparam logic [GEN_W-1:0]  QUOTA_V    = GEN_W'(REF_QUOTA);
  localparam logic [GAP_W-1:0]  GAP_LOAD   = GAP_W'(RC_CYCLES - 1);
  localparam logic [OWED_W-1:0] OWED_TOP   = OWED_W'(OWED_MAX);

  logic [PER_W-1:0]  periodCnt;
  logic [SPC_W-1:0]  spacingCnt;
  logic [GEN_W-1:0]  genCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [OWED_W-1:0] owedCnt;

  always_comb begin
    flags.periodStart = (periodCnt == '0);
    flags.periodEnd   = (periodCnt == PER_LAST);
    flags.hitSpread   = (spacingCnt == SPR_LAST);
    flags.hitBurst    = (spacingCnt == BRS_LAST);
    flags.quotaDone   = (genCnt == QUOTA_V);
    flags.reqLive     = (owedCnt != '0) && (gapCnt == '0);
    flags.owedAtMax   = (owedCnt == OWED_TOP);
  end

  assign owedCount = owedCnt;

  // refresh period timer, restarts at reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                periodCnt <= '0;
    else if (flags.periodEnd) periodCnt <= '0;
    else                      periodCnt <= periodCnt + 1'b1;
  end

  // spacing between due refreshes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       spacingCnt <= '0;
    else if (strobes.spacingRestart) spacingCnt <= '0;
    else                             spacingCnt <= spacingCnt + 1'b1;
  end

  // refreshes generated in the current period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                genCnt <= '0;
    else if (flags.periodEnd) genCnt <= '0;
    else if (strobes.tick)    genCnt <= genCnt + 1'b1;
  end

  // minimum gap after a grant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gapCnt <= '0;
    else if (strobes.accept)  gapCnt <= GAP_LOAD;
    else if (gapCnt != '0)    gapCnt <= gapCnt - 1'b1;
  end

  // owed refreshes, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owedCnt <= '0;
    else begin
      unique case ({strobes.tick, strobes.accept})
        2'b10:   if (owedCnt != OWED_TOP) owedCnt <= owedCnt + 1'b1;
        2'b01:   owedCnt <= owedCnt - 1'b1;
        default: owedCnt <= owedCnt;
      endcase
    end
  end

  // checker state: cycles since the last grant
  logic [GAP_W-1:0] sinceAcc;
  logic             seenAcc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAcc <= '0;
      seenAcc  <= 1'b0;
    end else if (strobes.accept) begin
      sinceAcc <= '0;
      seenAcc  <= 1'b1;
    end else if (sinceAcc != GAP_LOAD) begin
      sinceAcc <= sinceAcc + 1'b1;
    end
  end

  assert_owed_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    owedCnt <= OWED_TOP);

  assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (owedCnt == OWED_TOP) && !strobes.accept |=> owedCnt == OWED_TOP);

  assert_retire_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept && !strobes.tick |=> owedCnt == $past(owedCnt) - 1'b1);

  assert_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept && seenAcc |-> sinceAcc == GAP_LOAD);

  assert_quota_R4: assert property (@(posedge clk) disable iff (!rstN)
    genCnt <= QUOTA_V);

endmodule

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeBurst,
  input  logic         refAck,
  input  dpFlags_t     flags,
  output ctrlStrobes_t strobes
);

  logic modeCur;
  logic selBurst;
  logic spaceHit;

  // mode is taken from the input only in the first cycle of a period
  assign selBurst = flags.periodStart ? modeBurst : modeCur;
  assign spaceHit = selBurst ? flags.hitBurst : flags.hitSpread;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeCur <= 1'b0;
    else       modeCur <= selBurst;
  end

  always_comb begin
    strobes.spacingRestart = spaceHit || flags.periodEnd;
    strobes.tick           = spaceHit && !flags.quotaDone;
    strobes.accept         = flags.reqLive && refAck;
  end

  assert_mode_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    !flags.periodStart |=> $stable(modeCur));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int REF_PERIOD = 6400000,
  parameter int REF_QUOTA  = 4096,
  parameter int RC_CYCLES  = 7,
  parameter int OWED_MAX   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          modeBurst,
  input  logic                          refAck,
  output logic                          refReq,
  output logic [$clog2(OWED_MAX+1)-1:0] owedCount,
  output logic                          owedFull
);

  ctrlStrobes_t strobes;
  dpFlags_t     flags;

  refresh_sched_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeBurst (modeBurst),
    .refAck    (refAck),
    .flags     (flags),
    .strobes   (strobes)
  );

  refresh_sched_dp #(
    .REF_PERIOD (REF_PERIOD),
    .REF_QUOTA  (REF_QUOTA),
    .RC_CYCLES  (RC_CYCLES),
    .OWED_MAX   (OWED_MAX)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .flags     (flags),
    .owedCount (owedCount)
  );

  assign refReq   = flags.reqLive;
  assign owedFull = flags.owedAtMax;

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    refReq && !refAck |=> refReq);

  assert_ack_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !refReq && refAck |=> owedCount >= $past(owedCount));

endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;

  localparam int CLK_PERIOD = 10;
  localparam int PER  = 100;
  localparam int QTA  = 8;
  localparam int RC   = 5;
  localparam int OMAX = 8;
  localparam int IVL  = PER / QTA;  // 12

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeBurst = 1'b0;
  logic       refAck = 1'b1;
  logic       refReq;
  logic [3:0] owedCount;
  logic       owedFull;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  int expQ[$];

  refresh_sched #(
    .REF_PERIOD (PER),
    .REF_QUOTA  (QTA),
    .RC_CYCLES  (RC),
    .OWED_MAX   (OMAX)
  ) dut (
    .clk       (clk),
    .rstN      (rstN),
    .modeBurst (modeBurst),
    .refAck    (refAck),
    .refReq    (refReq),
    .owedCount (owedCount),
    .owedFull  (owedFull)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: expected grant cycles
  task automatic pushExp(input int first, input int step, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(first + i * step);
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: every grant is compared with the next expected cycle
  always @(negedge clk) begin
    if (rstN && !finished && refReq && refAck) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected grant", cyc, -1);
      end else begin
        int e;
        e = expQ.pop_front();
        check(cyc == e, "R2/R3/R7 grant cycle", cyc, e);
      end
    end
  end

  task automatic finish();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    check(1'b0, "watchdog", cyc, 0);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset, with acknowledge already high
    check(refReq == 1'b0, "R1 req in reset", int'(refReq), 0);
    check(owedCount == 4'd0, "R1 owed in reset", int'(owedCount), 0);
    check(owedFull == 1'b0, "R1 full in reset", int'(owedFull), 0);

    // spread periods 0 and 100, burst at 200 and 300
    pushExp(IVL, IVL, QTA);
    pushExp(PER + IVL, IVL, QTA);
    pushExp(2*PER + RC, RC, QTA);
    pushExp(3*PER + RC, RC, QTA);
    // drain after the acknowledge is withheld, then burst at 600, spread at 700
    pushExp(560, RC, QTA);
    pushExp(6*PER + RC, RC, QTA);
    pushExp(7*PER + IVL, IVL, QTA);

    rstN = 1'b1;
    @(negedge clk);
    check(refReq == 1'b0, "R1 req after reset", int'(refReq), 0);
    check(owedCount == 4'd0, "R1 owed after reset", int'(owedCount), 0);

    // R6: acknowledge held high with nothing owed has no effect
    waitCyc(50);
    check(owedCount == 4'd0, "R6 idle ack owed", int'(owedCount), 0);

    // R5: switch to burst mid-period, effective at 200
    waitCyc(150);
    modeBurst = 1'b1;

    // withhold acknowledge after the burst at 300
    waitCyc(350);
    refAck = 1'b0;
    waitCyc(420);
    check(owedCount == 4'd4, "R9 owed count rising", int'(owedCount), 4);
    waitCyc(430);
    check(owedFull == 1'b0, "R8 not yet full", int'(owedFull), 0);
    waitCyc(450);
    check(owedCount == 4'd8, "R8 owed at max", int'(owedCount), 8);
    check(owedFull == 1'b1, "R8 full flag", int'(owedFull), 1);
    check(refReq == 1'b1, "R6 req held while not granted", int'(refReq), 1);
    waitCyc(545);
    check(owedCount == 4'd8, "R8 saturation keeps max", int'(owedCount), 8);

    // release: 8 grants spaced by RC (R7), then nothing owed
    waitCyc(560);
    refAck = 1'b1;
    waitCyc(597);
    check(owedCount == 4'd0, "R8 lost refreshes not kept", int'(owedCount), 0);
    check(owedFull == 1'b0, "R8 full cleared", int'(owedFull), 0);

    // R5: back to spread mid-burst, effective at 700
    waitCyc(620);
    modeBurst = 1'b0;

    waitCyc(800);
    check(expQ.size() == 0, "R4 all expected grants seen", expQ.size(), 0);
    finish();
  end

endmodule